// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block produces the 24-bit physical bus address and keeps the remaining transfer count for a single legacy-style DMA channel. A parameter chosen at elaboration time makes the channel either a byte channel or a word channel. Software-side logic presents a start address, a start count, a page value and two mode controls, and pulses a load strobe. From then on, each step strobe stands for one completed bus transfer. On every accepted step the current address moves by one unit, upward or downward, and the current count goes down by one.

The count is held as the number of transfers minus one, so the channel ends on the step that takes the count below zero. A one-cycle terminal-count flag marks that step. If autoinitialize is off, the channel then ignores steps until the next load. If it is on, the start address and start count are copied back into the current registers and the channel keeps running. The page value is never incremented by the address counter. The 16-bit address therefore wraps inside a 64K page on a byte channel and inside a 128K page on a word channel.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, bus_addr, cur_count and tc are all zero, and step pulses have no effect until the first load.
- R2: A load copies base_addr_in into the current address and base_cnt_in into the current count. It also captures page_in and both mode inputs. The new values are visible in the cycle after the load edge, and tc is low in that cycle.
- R3: On a byte channel (WORD_CHAN = 0), bus_addr[23:16] is the captured page and bus_addr[15:0] is the current address.
- R4: On a word channel (WORD_CHAN = 1), bus_addr[23:17] is page bits 7..1, bus_addr[16:1] is the current address and bus_addr[0] is 0. Page bit 0 has no effect.
- R5: An accepted step adds one to the current address when mode_dec is 0 and subtracts one when mode_dec is 1. It also lowers cur_count by one.
- R6: Address stepping never changes the page bits. Incrementing from 0xFFFF gives 0x0000, and decrementing from 0x0000 gives 0xFFFF, within the same page.
- R7: A step accepted while cur_count is 0 raises tc for exactly the next cycle. With mode_autoinit at 0, cur_count then reads 0xFFFF and the address has advanced once more.
- R8: With mode_autoinit at 0, steps after terminal count change neither bus_addr nor cur_count until the next load.
- R9: With mode_autoinit at 1, the terminal-count step reloads the current address and count from the captured start values. Steps continue to be accepted afterwards.
- R10: When load and step are high in the same cycle, the load wins and the step is dropped.
- R11: A loaded count of N gives exactly N+1 accepted steps before terminal count. A count of 0 gives one step and a count of 0xFFFF gives 65536 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Captures the start values and arms the channel |
| base_addr_in | input | 16 | Start address (in bytes or in words) |
| base_cnt_in | input | 16 | Start count, transfers minus one |
| page_in | input | 8 | Page value placed above the address |
| mode_autoinit | input | 1 | Reload the start values at terminal count |
| mode_dec | input | 1 | Count the address downward |
| step | input | 1 | One transfer completed |
| bus_addr | output | 24 | Physical bus address |
| tc | output | 1 | Terminal-count pulse |
| cur_count | output | 16 | Current count, for residue readback |

## Verification
The assertions assume that load and step are single-cycle synchronous strobes with no X values after reset. They also assume that a step arriving while the channel is idle is legal, so the inputs carry no protocol rule beyond those strobes. Both channel variants run in parallel from the same stimulus. The random stimulus draws small start counts, so terminal count, autoinitialize reload and idle periods all recur often. Directed sequences cover the full 65536-step count and wrapping in both directions.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  typedef struct packed {
    logic autoinit;
    logic dec;
  } chan_mode_t;
endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic [AW-1:0] reload_val,
  input  logic          adv,
  input  logic          dec,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] cur_d;
  logic          cur_en;

  // The address wraps at AW bits; nothing propagates upward into the page.
  always_comb begin
    cur_en = reload | adv;
    cur_d  = cur;
    if (reload)   cur_d = reload_val;
    else if (adv) cur_d = dec ? cur - 1'b1 : cur + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur <= '0;
    else if (cur_en) cur <= cur_d;
  end
endmodule

// File: rtl/dma_count_ctr.sv
module dma_count_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic [CW-1:0] reload_val,
  input  logic          dec_en,
  output logic [CW-1:0] cur,
  output logic          at_zero
);
  logic [CW-1:0] cur_d;
  logic          cur_en;

  always_comb begin
    cur_en = reload | dec_en;
    cur_d  = cur;
    if (reload)      cur_d = reload_val;
    else if (dec_en) cur_d = cur - 1'b1;
  end

  assign at_zero = (cur == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur <= '0;
    else if (cur_en) cur <= cur_d;
  end
endmodule

// File: rtl/dma_addr_map.sv
module dma_addr_map #(
  parameter int AW        = 16,
  parameter int PW        = 8,
  parameter bit WORD_CHAN = 1'b0,
  localparam int BUS_W    = AW + PW
) (
  input  logic [PW-1:0]    page,
  input  logic [AW-1:0]    cur_addr,
  output logic [BUS_W-1:0] bus_addr
);
  generate
    if (WORD_CHAN) begin : g_word
      // Word units: the address shifts up one bit, and the lowest page bit
      // overlaps it and is dropped.
      assign bus_addr = {page[PW-1:1], cur_addr, page[0] & 1'b0};
    end else begin : g_byte
      assign bus_addr = {page, cur_addr};
    end
  endgenerate
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_eng_pkg::*;
#(
  parameter int AW        = 16,
  parameter int CW        = 16,
  parameter int PW        = 8,
  parameter bit WORD_CHAN = 1'b0,
  localparam int BUS_W    = AW + PW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    base_addr_in,
  input  logic [CW-1:0]    base_cnt_in,
  input  logic [PW-1:0]    page_in,
  input  logic             mode_autoinit,
  input  logic             mode_dec,
  input  logic             step,
  output logic [BUS_W-1:0] bus_addr,
  output logic             tc,
  output logic [CW-1:0]    cur_count
);
  chan_mode_t    mode_q;
  logic [AW-1:0] base_addr_q;
  logic [CW-1:0] base_cnt_q;
  logic [PW-1:0] page_q;
  logic          armed_q, armed_d;
  logic          tc_q, tc_d;
  logic [AW-1:0] cur_addr;
  logic          cnt_zero;

  logic          step_ok, last_step, auto_reload;
  logic          addr_reload, cnt_reload, addr_adv, cnt_dec;
  logic [AW-1:0] addr_rl_val;
  logic [CW-1:0] cnt_rl_val;

  always_comb begin
    step_ok     = step & armed_q & ~load;
    last_step   = step_ok & cnt_zero;
    auto_reload = last_step & mode_q.autoinit;
    addr_reload = load | auto_reload;
    cnt_reload  = load | auto_reload;
    addr_adv    = step_ok & ~auto_reload;
    cnt_dec     = step_ok & ~auto_reload;
    addr_rl_val = load ? base_addr_in : base_addr_q;
    cnt_rl_val  = load ? base_cnt_in  : base_cnt_q;
    tc_d        = last_step;
    armed_d     = armed_q;
    if (load)                                armed_d = 1'b1;
    else if (last_step && !mode_q.autoinit)  armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      page_q      <= '0;
      mode_q      <= '0;
    end else if (load) begin
      base_addr_q <= base_addr_in;
      base_cnt_q  <= base_cnt_in;
      page_q      <= page_in;
      mode_q      <= '{autoinit: mode_autoinit, dec: mode_dec};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      tc_q    <= 1'b0;
    end else begin
      armed_q <= armed_d;
      tc_q    <= tc_d;
    end
  end

  dma_addr_ctr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .reload(addr_reload), .reload_val(addr_rl_val),
    .adv(addr_adv), .dec(mode_q.dec), .cur(cur_addr)
  );

  dma_count_ctr #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .reload(cnt_reload), .reload_val(cnt_rl_val),
    .dec_en(cnt_dec), .cur(cur_count), .at_zero(cnt_zero)
  );

  dma_addr_map #(.AW(AW), .PW(PW), .WORD_CHAN(WORD_CHAN)) u_map (
    .page(page_q), .cur_addr(cur_addr), .bus_addr(bus_addr)
  );

  assign tc = tc_q;
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int AW        = 16,
  parameter int CW        = 16,
  parameter int PW        = 8,
  parameter bit WORD_CHAN = 1'b0,
  localparam int BUS_W    = AW + PW
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             step,
  input logic             armed,
  input logic             autoinit,
  input logic [CW-1:0]    base_cnt_q,
  input logic [CW-1:0]    base_cnt_in,
  input logic [CW-1:0]    cur_count,
  input logic [BUS_W-1:0] bus_addr,
  input logic             tc
);
  assert_load_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_count == $past(base_cnt_in)) && !tc);

  assert_count_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && armed && !load && cur_count != '0) |=> cur_count == $past(cur_count) - 1'b1);

  assert_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(bus_addr[BUS_W-1:AW+1]));

  assert_tc_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> $past(step) && !$past(load) && $past(cur_count) == '0);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !load) |=> $stable(cur_count) && $stable(bus_addr) && !tc);

  assert_autoinit_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && armed && !load && cur_count == '0 && autoinit) |=> cur_count == $past(base_cnt_q));

  generate
    if (WORD_CHAN) begin : g_word_chk
      assert_word_a0_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[0] == 1'b0);
    end
  endgenerate
endmodule

bind dma_chan_engine dma_chan_engine_chk #(
  .AW(AW), .CW(CW), .PW(PW), .WORD_CHAN(WORD_CHAN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .step(step), .armed(armed_q),
  .autoinit(mode_q.autoinit), .base_cnt_q(base_cnt_q), .base_cnt_in(base_cnt_in),
  .cur_count(cur_count), .bus_addr(bus_addr), .tc(tc)
);

// File: tb/tb_dma_chan_engine.sv
`timescale 1ns/1ps
module tb_dma_chan_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load, step, mode_autoinit, mode_dec;
  logic [15:0] base_addr_in, base_cnt_in;
  logic [7:0]  page_in;
  logic [23:0] bus_b, bus_w;
  logic        tc_b, tc_w;
  logic [15:0] cnt_b, cnt_w;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [15:0] m_addr, m_cnt, m_ba, m_bc;
  logic [7:0]  m_page;
  logic        m_auto, m_dec, m_armed, m_tc;

  always #5 clk = ~clk;

  dma_chan_engine #(.WORD_CHAN(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .load(load), .base_addr_in(base_addr_in),
    .base_cnt_in(base_cnt_in), .page_in(page_in), .mode_autoinit(mode_autoinit),
    .mode_dec(mode_dec), .step(step), .bus_addr(bus_b), .tc(tc_b), .cur_count(cnt_b));

  dma_chan_engine #(.WORD_CHAN(1'b1)) dut_w (
    .clk(clk), .rst_n(rst_n), .load(load), .base_addr_in(base_addr_in),
    .base_cnt_in(base_cnt_in), .page_in(page_in), .mode_autoinit(mode_autoinit),
    .mode_dec(mode_dec), .step(step), .bus_addr(bus_w), .tc(tc_w), .cur_count(cnt_w));

  function automatic logic [23:0] map_byte(logic [7:0] pg, logic [15:0] a);
    return {pg, a};
  endfunction

  function automatic logic [23:0] map_word(logic [7:0] pg, logic [15:0] a);
    return ({16'd0, pg & 8'hFE} << 16) | ({8'd0, a} << 1);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge(bit ld, bit st);
    if (ld) begin
      m_addr = base_addr_in; m_cnt = base_cnt_in; m_ba = base_addr_in; m_bc = base_cnt_in;
      m_page = page_in; m_auto = mode_autoinit; m_dec = mode_dec; m_armed = 1'b1; m_tc = 1'b0;
    end else if (st && m_armed) begin
      m_tc = (m_cnt == 16'd0);
      if (m_tc && m_auto) begin
        m_addr = m_ba; m_cnt = m_bc;
      end else begin
        m_addr = m_dec ? m_addr - 16'd1 : m_addr + 16'd1;
        m_cnt  = m_cnt - 16'd1;
        if (m_tc) m_armed = 1'b0;
      end
    end else m_tc = 1'b0;
  endtask

  task automatic tick(string tag, bit ld, bit st, logic [15:0] ba, logic [15:0] bc,
                      logic [7:0] pg, bit au, bit dc);
    load = ld; step = st; base_addr_in = ba; base_cnt_in = bc; page_in = pg;
    mode_autoinit = au; mode_dec = dc;
    @(posedge clk);
    model_edge(ld, st);
    @(negedge clk);
    load = 1'b0; step = 1'b0;
    check({tag, " byte addr R3"}, {8'd0, bus_b}, {8'd0, map_byte(m_page, m_addr)});
    check({tag, " word addr R4"}, {8'd0, bus_w}, {8'd0, map_word(m_page, m_addr)});
    check({tag, " count"}, {16'd0, cnt_b}, {16'd0, m_cnt});
    check({tag, " word count"}, {16'd0, cnt_w}, {16'd0, m_cnt});
    check({tag, " tc"}, {31'd0, tc_b}, {31'd0, m_tc});
    check({tag, " word tc"}, {31'd0, tc_w}, {31'd0, m_tc});
  endtask

  task automatic do_step(string tag);
    tick(tag, 1'b0, 1'b1, 16'd0, 16'd0, 8'd0, 1'b0, 1'b0);
  endtask

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int tc_seen;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; load = 1'b0; step = 1'b0; base_addr_in = '0; base_cnt_in = '0;
    page_in = '0; mode_autoinit = 1'b0; mode_dec = 1'b0;
    m_addr = '0; m_cnt = '0; m_ba = '0; m_bc = '0; m_page = '0;
    m_auto = 1'b0; m_dec = 1'b0; m_armed = 1'b0; m_tc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, then steps before any load
    check("R1 reset addr", {8'd0, bus_b}, 32'd0);
    check("R1 reset count", {16'd0, cnt_b}, 32'd0);
    check("R1 reset tc", {31'd0, tc_b}, 32'd0);
    repeat (3) do_step("R1 step before load");
    check("R1 ignored step", {8'd0, bus_b}, 32'd0);

    // R2, R3, R4: load and mapping
    tick("R2 load", 1'b1, 1'b0, 16'h1234, 16'd2, 8'hA5, 1'b0, 1'b0);
    check("R3 byte map", {8'd0, bus_b}, 32'h00A51234);
    check("R4 word map", {8'd0, bus_w}, 32'h00A42468);
    check("R2 count", {16'd0, cnt_b}, 32'd2);
    // R5, R7, R11: count 2 gives three steps
    do_step("R5 step1");
    check("R5 incr", {8'd0, bus_b}, 32'h00A51235);
    do_step("R5 step2");
    do_step("R7 step3");
    check("R7 tc", {31'd0, tc_b}, 32'd1);
    check("R7 count ffff", {16'd0, cnt_b}, 32'h0000FFFF);
    check("R11 three steps", {8'd0, bus_b}, 32'h00A51237);
    // R8: steps after terminal count
    repeat (4) do_step("R8 idle step");
    check("R8 addr held", {8'd0, bus_b}, 32'h00A51237);
    check("R8 count held", {16'd0, cnt_b}, 32'h0000FFFF);

    // R6: wrap upward and downward inside the page
    tick("R6 load up", 1'b1, 1'b0, 16'hFFFE, 16'd5, 8'h3C, 1'b0, 1'b0);
    repeat (3) do_step("R6 up");
    check("R6 wrap up", {8'd0, bus_b}, 32'h003C0001);
    tick("R6 load down", 1'b1, 1'b0, 16'h0001, 16'd5, 8'h3D, 1'b0, 1'b1);
    repeat (2) do_step("R6 down");
    check("R6 wrap down", {8'd0, bus_b}, 32'h003DFFFF);
    check("R6 word wrap down", {8'd0, bus_w}, 32'h003DFFFE);

    // R9: autoinitialize
    tick("R9 load", 1'b1, 1'b0, 16'h0100, 16'd1, 8'h12, 1'b1, 1'b0);
    repeat (2) do_step("R9 run");
    check("R9 tc", {31'd0, tc_b}, 32'd1);
    check("R9 reload addr", {8'd0, bus_b}, 32'h00120100);
    check("R9 reload count", {16'd0, cnt_b}, 32'd1);
    do_step("R9 continues");
    check("R9 still stepping", {8'd0, bus_b}, 32'h00120101);

    // R10: load and step together
    tick("R10 load+step", 1'b1, 1'b1, 16'h4000, 16'd7, 8'h01, 1'b0, 1'b0);
    check("R10 step dropped", {8'd0, bus_b}, 32'h00014000);
    check("R10 count", {16'd0, cnt_b}, 32'd7);

    // R11: count 0 is one transfer, count ffff is 65536
    tick("R11 load zero", 1'b1, 1'b0, 16'h0010, 16'd0, 8'h02, 1'b0, 1'b0);
    do_step("R11 single");
    check("R11 single tc", {31'd0, tc_b}, 32'd1);
    tick("R11 load max", 1'b1, 1'b0, 16'h0000, 16'hFFFF, 8'h07, 1'b0, 1'b0);
    tc_seen = 0;
    for (int i = 1; i <= 65536; i++) begin
      do_step("R11 long");
      if (tc_b && tc_seen == 0) tc_seen = i;
    end
    check("R11 65536 steps", tc_seen, 32'd65536);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit ld = ($urandom_range(0, 19) == 0);
      tick("R5 random", ld, $urandom_range(0, 1) == 1, 16'($urandom()),
           16'($urandom_range(0, 7)), 8'($urandom()), $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule